// File: doc/BRIEF.md
# NAND Asynchronous Bus Mode Decoder

This block is the device-side front end of an asynchronous NAND flash target. It watches the chip-enable, latch-enable, strobe and write-protect pins and an 8-bit bus that carries commands, addresses and data in both directions. It sorts every bus cycle into one of a small set of modes and turns write-enable strobes into one-cycle command, address or data events for the target's core. It drives the bus during reads and never enables the data strobe output. It also decides when the target may drop into low-power standby, based on the busy lines of its logical units.

Every pin first passes through a two-stage synchronizer into the internal clock domain, and strobe edges are detected on the synchronized copies. A write strobe is taken on its rising edge. The block has no command decoding, array timing or synchronous-interface logic.

Top module: `nand_async_front`

## Requirements
- R1: After reset the block reports `mode_o` = 0 (standby), `standby_o` = 1, `byte_o` = 0, `dq_oe_o` = 0, and no event pulses.
- R2: With chip enable low, CLE high and ALE low, a rising write-enable edge produces exactly one `cmd_valid_o` pulse, one clock wide, and `byte_o` then holds the bus byte.
- R3: With chip enable low, CLE low and ALE high, a rising write-enable edge produces exactly one `addr_valid_o` pulse, and `byte_o` then holds the bus byte.
- R4: With chip enable low and both CLE and ALE low, a rising write-enable edge produces exactly one `din_valid_o` pulse, and `byte_o` then holds the bus byte.
- R5: A rising write-enable edge with CLE and ALE both high produces no command, address or data event, leaves `byte_o` unchanged, and raises `illegal_o` for one clock.
- R6: While chip enable is high, strobes on write enable and read enable cause no event, no change to `byte_o`, and no drive of the bus, even if a logical unit is busy.
- R7: With chip enable low, CLE and ALE low and read enable low, `dq_oe_o` is 1 and `dq_o` equals `rd_data_i`; `dq_oe_o` falls as soon as read enable rises, and each read-enable rising edge in this mode produces one `rd_next_o` pulse.
- R8: `dqs_oe_o` is 0 at all times.
- R9: With chip enable low and both strobes high, `mode_o` = 2 (idle), nothing is captured and `dq_oe_o` = 0. While a strobe is low, `mode_o` is 3 (command), 4 (address), 5 (data in), 6 (data out) or 7 (CLE and ALE both high).
- R10: With chip enable high, `standby_o` = 1 and `mode_o` = 0 only when no `lun_busy_i` bit is set; if any is set, `standby_o` = 0 and `mode_o` = 1, and standby follows once every busy bit has cleared.
- R11: Write protect low sets `wp_active_o` to 1 whatever the state of the other pins, chip enable included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ce_ni | input | 1 | Chip enable pin, active low |
| cle_i | input | 1 | Command latch enable pin |
| ale_i | input | 1 | Address latch enable pin |
| we_ni | input | 1 | Write enable pin, active low, captures on rising edge |
| re_ni | input | 1 | Read enable pin, active low |
| wp_ni | input | 1 | Write protect pin, active low |
| dq_i | input | 8 | Bus value as seen at the pins |
| dq_o | output | 8 | Bus value driven during data output |
| dq_oe_o | output | 1 | Bus output enable |
| dqs_oe_o | output | 1 | Data strobe output enable, held low |
| lun_busy_i | input | NUM_LUNS | Busy flag from each logical unit |
| rd_data_i | input | 8 | Next read byte from the core |
| mode_o | output | 3 | Current bus mode code |
| cmd_valid_o | output | 1 | Command byte event |
| addr_valid_o | output | 1 | Address byte event |
| din_valid_o | output | 1 | Data-in byte event |
| rd_next_o | output | 1 | Read byte consumed, core should advance |
| illegal_o | output | 1 | Strobe with both latch enables high |
| byte_o | output | 8 | Last captured byte |
| wp_active_o | output | 1 | Write protect in force |
| standby_o | output | 1 | Target in low-power standby |

## Verification
The bench builds the block with its defaults: two logical units, two synchronizer stages and an 8-bit bus. Two busy lines let it hold one unit busy while the other is idle, so the deferral of standby can be seen to wait for the last unit rather than the first. With two synchronizer stages every pin event reaches the outputs in a short fixed window, which lets each scenario count pulses over a few clocks and confirm that a strobe yields exactly one event of the right kind.

// File: rtl/nand_front_pkg.sv
package nand_front_pkg;
  typedef enum logic [2:0] {
    M_STANDBY  = 3'd0,
    M_DISABLED = 3'd1,
    M_IDLE     = 3'd2,
    M_CMD      = 3'd3,
    M_ADDR     = 3'd4,
    M_DIN      = 3'd5,
    M_DOUT     = 3'd6,
    M_CONFLICT = 3'd7
  } bus_mode_e;
endpackage

// File: rtl/nand_pin_sync.sv
module nand_pin_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [W-1:0] nxt;
    if (g == 0) begin : g_first
      assign nxt = d_i;
    end else begin : g_next
      assign nxt = stage_q[g-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[g] <= RST_VAL;
      else         stage_q[g] <= nxt;
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/nand_standby_ctl.sv
module nand_standby_ctl #(
  parameter int unsigned NUM_LUNS = 2
) (
  input  logic                ce_n_s_i,
  input  logic [NUM_LUNS-1:0] busy_s_i,
  output logic                any_busy_o,
  output logic                standby_o
);
  // standby waits for the last busy unit, not for chip enable alone
  assign any_busy_o = |busy_s_i;
  assign standby_o  = ce_n_s_i & ~any_busy_o;
endmodule

// File: rtl/nand_bus_classify.sv
module nand_bus_classify
  import nand_front_pkg::*;
#(
  parameter int unsigned DQ_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ce_n_s_i,
  input  logic            cle_s_i,
  input  logic            ale_s_i,
  input  logic            we_n_s_i,
  input  logic            re_n_s_i,
  input  logic [DQ_W-1:0] dq_s_i,
  input  logic            any_busy_i,
  output bus_mode_e       mode_o,
  output logic            dout_sel_o,
  output logic            cmd_o,
  output logic            addr_o,
  output logic            din_o,
  output logic            illegal_o,
  output logic            rd_next_o,
  output logic [DQ_W-1:0] byte_o
);
  logic we_prev_q, re_prev_q;
  logic we_rise, re_rise;
  logic cmd_q, addr_q, din_q, ill_q, rdn_q;
  logic [DQ_W-1:0] byte_q;

  assign we_rise    = we_n_s_i & ~we_prev_q & ~ce_n_s_i;
  assign re_rise    = re_n_s_i & ~re_prev_q & ~ce_n_s_i;
  assign dout_sel_o = ~ce_n_s_i & ~re_n_s_i & ~cle_s_i & ~ale_s_i;

  always_comb begin
    if (ce_n_s_i)        mode_o = any_busy_i ? M_DISABLED : M_STANDBY;
    else if (dout_sel_o) mode_o = M_DOUT;
    else if (!we_n_s_i) begin
      unique case ({cle_s_i, ale_s_i})
        2'b10:   mode_o = M_CMD;
        2'b01:   mode_o = M_ADDR;
        2'b00:   mode_o = M_DIN;
        default: mode_o = M_CONFLICT;
      endcase
    end else             mode_o = M_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_prev_q <= 1'b1;
      re_prev_q <= 1'b1;
      cmd_q     <= 1'b0;
      addr_q    <= 1'b0;
      din_q     <= 1'b0;
      ill_q     <= 1'b0;
      rdn_q     <= 1'b0;
      byte_q    <= '0;
    end else begin
      we_prev_q <= we_n_s_i;
      re_prev_q <= re_n_s_i;
      cmd_q     <= we_rise &  cle_s_i & ~ale_s_i;
      addr_q    <= we_rise & ~cle_s_i &  ale_s_i;
      din_q     <= we_rise & ~cle_s_i & ~ale_s_i;
      ill_q     <= we_rise &  cle_s_i &  ale_s_i;
      rdn_q     <= re_rise & ~cle_s_i & ~ale_s_i;
      if (we_rise && !(cle_s_i && ale_s_i)) byte_q <= dq_s_i;
    end
  end

  assign cmd_o     = cmd_q;
  assign addr_o    = addr_q;
  assign din_o     = din_q;
  assign illegal_o = ill_q;
  assign rd_next_o = rdn_q;
  assign byte_o    = byte_q;
endmodule

// File: rtl/nand_async_front.sv
module nand_async_front
  import nand_front_pkg::*;
#(
  parameter int unsigned NUM_LUNS    = 2,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DQ_W        = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ce_ni,
  input  logic                cle_i,
  input  logic                ale_i,
  input  logic                we_ni,
  input  logic                re_ni,
  input  logic                wp_ni,
  input  logic [DQ_W-1:0]     dq_i,
  output logic [DQ_W-1:0]     dq_o,
  output logic                dq_oe_o,
  output logic                dqs_oe_o,
  input  logic [NUM_LUNS-1:0] lun_busy_i,
  input  logic [DQ_W-1:0]     rd_data_i,
  output logic [2:0]          mode_o,
  output logic                cmd_valid_o,
  output logic                addr_valid_o,
  output logic                din_valid_o,
  output logic                rd_next_o,
  output logic                illegal_o,
  output logic [DQ_W-1:0]     byte_o,
  output logic                wp_active_o,
  output logic                standby_o
);
  localparam int unsigned CTRL_W = 6;
  localparam int unsigned PIN_W  = CTRL_W + NUM_LUNS + DQ_W;
  // order: ce, cle, ale, we, re, wp, busy, dq; strobes and enables reset inactive
  localparam logic [PIN_W-1:0] PIN_RST = {6'b100111, {(NUM_LUNS + DQ_W){1'b0}}};

  logic [PIN_W-1:0]    pins_raw, pins_s;
  logic                ce_n_s, cle_s, ale_s, we_n_s, re_n_s, wp_n_s;
  logic [NUM_LUNS-1:0] busy_s;
  logic [DQ_W-1:0]     dq_s;
  logic                any_busy, dout_sel;
  bus_mode_e           mode;

  assign pins_raw = {ce_ni, cle_i, ale_i, we_ni, re_ni, wp_ni, lun_busy_i, dq_i};

  nand_pin_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_raw),
    .q_o   (pins_s)
  );

  assign {ce_n_s, cle_s, ale_s, we_n_s, re_n_s, wp_n_s, busy_s, dq_s} = pins_s;

  nand_standby_ctl #(.NUM_LUNS(NUM_LUNS)) u_stby (
    .ce_n_s_i  (ce_n_s),
    .busy_s_i  (busy_s),
    .any_busy_o(any_busy),
    .standby_o (standby_o)
  );

  nand_bus_classify #(.DQ_W(DQ_W)) u_cls (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ce_n_s_i  (ce_n_s),
    .cle_s_i   (cle_s),
    .ale_s_i   (ale_s),
    .we_n_s_i  (we_n_s),
    .re_n_s_i  (re_n_s),
    .dq_s_i    (dq_s),
    .any_busy_i(any_busy),
    .mode_o    (mode),
    .dout_sel_o(dout_sel),
    .cmd_o     (cmd_valid_o),
    .addr_o    (addr_valid_o),
    .din_o     (din_valid_o),
    .illegal_o (illegal_o),
    .rd_next_o (rd_next_o),
    .byte_o    (byte_o)
  );

  // raw pins gate the enable so the bus is released without sync delay
  assign dq_oe_o     = dout_sel & ~re_ni & ~ce_ni;
  assign dq_o        = rd_data_i;
  assign dqs_oe_o    = 1'b0;
  assign wp_active_o = ~wp_n_s;
  assign mode_o      = mode;
endmodule

// File: rtl/nand_front_chk.sv
module nand_front_chk
  import nand_front_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ce_ni,
  input logic       re_ni,
  input logic       dq_oe_o,
  input logic       dqs_oe_o,
  input logic [2:0] mode_o,
  input logic       cmd_valid_o,
  input logic       addr_valid_o,
  input logic       din_valid_o,
  input logic       illegal_o
);
  assert_oe_in_dout_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> (mode_o == M_DOUT) && !re_ni && !ce_ni);

  assert_dqs_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dqs_oe_o);

  assert_one_event_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cmd_valid_o, addr_valid_o, din_valid_o, illegal_o}));

  assert_illegal_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> !illegal_o);

  assert_cmd_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o);

  assert_addr_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_o |=> !addr_valid_o);
endmodule

bind nand_async_front nand_front_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ce_ni       (ce_ni),
  .re_ni       (re_ni),
  .dq_oe_o     (dq_oe_o),
  .dqs_oe_o    (dqs_oe_o),
  .mode_o      (mode_o),
  .cmd_valid_o (cmd_valid_o),
  .addr_valid_o(addr_valid_o),
  .din_valid_o (din_valid_o),
  .illegal_o   (illegal_o)
);

// File: tb/tb_nand_async_front.sv
module tb_nand_async_front;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ce_ni = 1'b1, cle_i = 1'b0, ale_i = 1'b0, we_ni = 1'b1, re_ni = 1'b1, wp_ni = 1'b1;
  logic [7:0] dq_i = '0, rd_data_i = '0;
  logic [1:0] lun_busy_i = '0;
  logic [7:0] dq_o, byte_o;
  logic       dq_oe_o, dqs_oe_o;
  logic [2:0] mode_o;
  logic       cmd_valid_o, addr_valid_o, din_valid_o, rd_next_o, illegal_o, wp_active_o, standby_o;

  int n_chk = 0, n_fail = 0;
  int c_cmd = 0, c_addr = 0, c_din = 0, c_ill = 0, c_rdn = 0, c_dqs = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  nand_async_front dut (.*);

  always @(negedge clk_i) begin
    if (rst_ni) begin
      c_cmd  += int'(cmd_valid_o);
      c_addr += int'(addr_valid_o);
      c_din  += int'(din_valid_o);
      c_ill  += int'(illegal_o);
      c_rdn  += int'(rd_next_o);
      c_dqs  += int'(dqs_oe_o);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic strobe(input logic c, input logic a, input logic [7:0] b);
    @(negedge clk_i);
    ce_ni = 1'b0; cle_i = c; ale_i = a; dq_i = b; we_ni = 1'b0;
    wait_n(4);
    we_ni = 1'b1;
    wait_n(6);
    cle_i = 1'b0; ale_i = 1'b0;
    wait_n(2);
  endtask

  task automatic t_reset_R1();
    check(mode_o == 3'd0, "R1 mode", mode_o, 0);
    check(standby_o == 1'b1, "R1 standby", standby_o, 1);
    check(byte_o == 8'h00, "R1 byte", byte_o, 0);
    check(dq_oe_o == 1'b0, "R1 oe", dq_oe_o, 0);
    check(c_cmd + c_addr + c_din + c_ill == 0, "R1 events", c_cmd + c_addr + c_din + c_ill, 0);
  endtask

  task automatic t_cmd_R2();
    int c0 = c_cmd, a0 = c_addr, d0 = c_din;
    strobe(1'b1, 1'b0, 8'h70);
    check(c_cmd - c0 == 1, "R2 cmd count", c_cmd - c0, 1);
    check(c_addr == a0 && c_din == d0, "R2 no other", c_addr + c_din, a0 + d0);
    check(byte_o == 8'h70, "R2 byte", byte_o, 8'h70);
  endtask

  task automatic t_addr_R3();
    int c0 = c_cmd, a0 = c_addr;
    strobe(1'b0, 1'b1, 8'hA5);
    check(c_addr - a0 == 1, "R3 addr count", c_addr - a0, 1);
    check(c_cmd == c0, "R3 no cmd", c_cmd, c0);
    check(byte_o == 8'hA5, "R3 byte", byte_o, 8'hA5);
    strobe(1'b0, 1'b1, 8'h3C);
    check(c_addr - a0 == 2 && byte_o == 8'h3C, "R3 second addr", byte_o, 8'h3C);
  endtask

  task automatic t_din_R4();
    int d0 = c_din;
    strobe(1'b0, 1'b0, 8'h96);
    check(c_din - d0 == 1, "R4 din count", c_din - d0, 1);
    check(byte_o == 8'h96, "R4 byte", byte_o, 8'h96);
  endtask

  task automatic t_illegal_R5();
    int e0 = c_cmd + c_addr + c_din, i0 = c_ill;
    strobe(1'b1, 1'b1, 8'hEE);
    check(c_ill - i0 == 1, "R5 illegal pulse", c_ill - i0, 1);
    check(c_cmd + c_addr + c_din == e0, "R5 no event", c_cmd + c_addr + c_din, e0);
    check(byte_o == 8'h96, "R5 byte kept", byte_o, 8'h96);
  endtask

  task automatic t_ce_high_R6();
    int e0 = c_cmd + c_addr + c_din + c_ill, r0 = c_rdn;
    @(negedge clk_i);
    ce_ni = 1'b1; lun_busy_i = 2'b10;
    wait_n(4);
    cle_i = 1'b1; dq_i = 8'h11; we_ni = 1'b0; wait_n(4); we_ni = 1'b1; wait_n(4);
    cle_i = 1'b0; re_ni = 1'b0; wait_n(4);
    check(dq_oe_o == 1'b0, "R6 no drive", dq_oe_o, 0);
    re_ni = 1'b1; wait_n(6);
    check(c_cmd + c_addr + c_din + c_ill == e0, "R6 no event", c_cmd + c_addr + c_din + c_ill, e0);
    check(c_rdn == r0, "R6 no read", c_rdn, r0);
    check(byte_o == 8'h96, "R6 byte kept", byte_o, 8'h96);
    lun_busy_i = 2'b00; wait_n(4);
  endtask

  task automatic t_dout_R7();
    int r0 = c_rdn;
    @(negedge clk_i);
    ce_ni = 1'b0; cle_i = 1'b0; ale_i = 1'b0; rd_data_i = 8'h5A; re_ni = 1'b0;
    wait_n(4);
    check(dq_oe_o == 1'b1, "R7 oe on", dq_oe_o, 1);
    check(dq_o == 8'h5A, "R7 data", dq_o, 8'h5A);
    check(mode_o == 3'd6, "R9 mode dout", mode_o, 6);
    re_ni = 1'b1; #1;
    check(dq_oe_o == 1'b0, "R7 release", dq_oe_o, 0);
    wait_n(6);
    check(c_rdn - r0 == 1, "R7 rd_next", c_rdn - r0, 1);
  endtask

  task automatic t_idle_R9();
    int e0 = c_cmd + c_addr + c_din + c_ill;
    @(negedge clk_i);
    ce_ni = 1'b0; we_ni = 1'b1; re_ni = 1'b1; cle_i = 1'b1;
    wait_n(4);
    check(mode_o == 3'd2, "R9 idle", mode_o, 2);
    check(dq_oe_o == 1'b0, "R9 no drive", dq_oe_o, 0);
    check(c_cmd + c_addr + c_din + c_ill == e0, "R9 no capture", c_cmd + c_addr + c_din + c_ill, e0);
    we_ni = 1'b0; wait_n(4);
    check(mode_o == 3'd3, "R9 mode cmd", mode_o, 3);
    ale_i = 1'b1; wait_n(4);
    check(mode_o == 3'd7, "R9 mode conflict", mode_o, 7);
    cle_i = 1'b0; wait_n(4);
    check(mode_o == 3'd4, "R9 mode addr", mode_o, 4);
    ale_i = 1'b0; wait_n(4);
    check(mode_o == 3'd5, "R9 mode din", mode_o, 5);
    we_ni = 1'b1; wait_n(6);
  endtask

  task automatic t_standby_R10();
    @(negedge clk_i);
    ce_ni = 1'b1; lun_busy_i = 2'b11;
    wait_n(4);
    check(standby_o == 1'b0, "R10 busy blocks", standby_o, 0);
    check(mode_o == 3'd1, "R10 disabled mode", mode_o, 1);
    lun_busy_i = 2'b10; wait_n(4);
    check(standby_o == 1'b0, "R10 one still busy", standby_o, 0);
    lun_busy_i = 2'b00; wait_n(4);
    check(standby_o == 1'b1, "R10 standby", standby_o, 1);
    check(mode_o == 3'd0, "R10 standby mode", mode_o, 0);
  endtask

  task automatic t_wp_R11();
    @(negedge clk_i);
    check(wp_active_o == 1'b0, "R11 wp idle", wp_active_o, 0);
    wp_ni = 1'b0; wait_n(4);
    check(wp_active_o == 1'b1, "R11 wp ce high", wp_active_o, 1);
    ce_ni = 1'b0; wait_n(4);
    check(wp_active_o == 1'b1, "R11 wp ce low", wp_active_o, 1);
    wp_ni = 1'b1; wait_n(4);
    check(wp_active_o == 1'b0, "R11 wp released", wp_active_o, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      check(c_dqs == 0, "R8 dqs", c_dqs, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    wait_n(3);
    rst_ni = 1'b1;
    wait_n(4);
    t_reset_R1();
    t_cmd_R2();
    t_addr_R3();
    t_din_R4();
    t_illegal_R5();
    t_ce_high_R6();
    t_dout_R7();
    t_idle_R9();
    t_standby_R10();
    t_wp_R11();
    finish_run();
  end

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end
endmodule